// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block is the programmable feedback divider of a frequency-synthesiser loop. It works on the clock it divides. A dual-modulus prescaler divides by 16 or by 17, and the block models it digitally with a small down-counter. A 4-bit swallow counter keeps the prescaler at modulus 17 for the first A prescaler cycles of each division period. A main counter counts M prescaler cycles in total. One division period therefore lasts 16·M + A input cycles. At the last cycle of each period the block raises a one-cycle output pulse.

The division word is written through a simple write-strobe interface. Its low 4 bits are A and the bits above them are M. Any word below 240 is raised to 240 when it is written, so the swallow count can never exceed the main count. A written word waits in a pending register and takes over only when the running period ends. The division period therefore never changes partway through.

The parameter `MAIN_W` selects the width of the main counter. A value of 11 gives a 15-bit word with a largest ratio of 32767, for the up loop. A value of 12 gives a 16-bit word with a largest ratio of 65535, for the down loop.

Top module: `psw_divider`

## Requirements
- R1: After reset the active ratio is 240 and `pulse_o` is low. The first pulse appears in the 240th cycle after reset is released.
- R2: `pulse_o` is high for exactly one input cycle per division period and is never high in two consecutive cycles.
- R3: The period in input cycles is 16·M + A. A is `word_i[3:0]` and M is `word_i[WORD_W-1:4]`, so the period equals the word's unsigned value.
- R4: A written word below 240, including 0, is treated as 240.
- R5: A word written during a period does not change that period. It becomes active at the next period boundary. A word written in the cycle where the pulse is high takes effect one boundary later.
- R6: Without a new write the active ratio repeats period after period. If several words are written before a boundary, the last one written is loaded.
- R7: Within each period, the first A prescaler cycles are 17 input cycles long and the remaining M−A are 16 cycles long. The swallow count never exceeds the remaining main count.
- R8: With `MAIN_W` = 11 the largest ratio is 32767, and with `MAIN_W` = 12 it is 65535. Both are divided exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, the signal being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| word_wr_i | input | 1 | Write strobe for the division word |
| word_i | input | MAIN_W+4 | Division word: bits [3:0] swallow count, upper bits main count |
| pulse_o | output | 1 | One-cycle pulse at the last cycle of each division period |

## Verification
The assertions check several properties on every cycle. The measured period at each pulse must equal the active word. The pulse must never last two cycles. The active word must change only after a pulse, and any pending word must be at least 240. The swallow count must never exceed the main count, and the 17-cycle prescaler state may occur only while swallows remain. Other behaviours only the bench scenarios can show:
- clamping of words below 240 as seen at the output;
- the last-write-wins rule;
- the extra period of delay for a word written in the pulse cycle;
- the exact largest ratios at both counter widths.

The bench runs an 11-bit and a 12-bit instance side by side for these scenarios.

// File: rtl/psw_pkg.sv
package psw_pkg;
    localparam int unsigned PSW_SWAL_W    = 4;
    localparam int unsigned PSW_PRE_W     = 5;
    localparam int unsigned PSW_MIN_RATIO = 240;
    localparam int unsigned PSW_MOD_LO    = 16;
endpackage

// File: rtl/psw_word_reg.sv
module psw_word_reg
    import psw_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              take_i,
    output logic [WORD_W-1:0] pend_o,
    output logic              pend_vld_o
);
    localparam logic [WORD_W-1:0] MIN_WORD = WORD_W'(PSW_MIN_RATIO);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              vld;
    } wreg_t;

    wreg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_i) st_d.vld = 1'b0;
        if (wr_i) begin
            st_d.word = (word_i < MIN_WORD) ? MIN_WORD : word_i;
            st_d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.word <= MIN_WORD;
            st_q.vld  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o     = st_q.word;
    assign pend_vld_o = st_q.vld;

    // R4
    pend_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> (st_q.word >= MIN_WORD));
endmodule

// File: rtl/psw_counter.sv
module psw_counter
    import psw_pkg::*;
#(
    parameter int unsigned MAIN_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [MAIN_W+PSW_SWAL_W-1:0] nxt_word_i,
    input  logic                       nxt_vld_i,
    output logic                       term_o
);
    localparam int unsigned WORD_W = MAIN_W + PSW_SWAL_W;
    localparam logic [WORD_W-1:0]     RST_WORD = WORD_W'(PSW_MIN_RATIO);
    localparam logic [PSW_PRE_W-1:0]  PRE_LO   = PSW_PRE_W'(PSW_MOD_LO - 1);
    localparam logic [PSW_PRE_W-1:0]  PRE_HI   = PSW_PRE_W'(PSW_MOD_LO);

    typedef struct packed {
        logic [WORD_W-1:0]     act;
        logic [MAIN_W-1:0]     main;
        logic [PSW_SWAL_W-1:0] swal;
        logic [PSW_PRE_W-1:0]  pre;
    } cnt_t;

    cnt_t st_d, st_q;
    logic pre_end;
    logic [WORD_W-1:0] load_w;
    logic [PSW_SWAL_W-1:0] swal_nx;

    assign pre_end = (st_q.pre == '0);
    assign term_o  = pre_end && (st_q.main == MAIN_W'(1));
    assign load_w  = nxt_vld_i ? nxt_word_i : st_q.act;

    always_comb begin
        st_d    = st_q;
        swal_nx = st_q.swal;
        if (term_o) begin
            st_d.act  = load_w;
            st_d.main = load_w[WORD_W-1:PSW_SWAL_W];
            st_d.swal = load_w[PSW_SWAL_W-1:0];
            st_d.pre  = (load_w[PSW_SWAL_W-1:0] != '0) ? PRE_HI : PRE_LO;
        end else if (pre_end) begin
            if (st_q.swal != '0) swal_nx = st_q.swal - 1'b1;
            st_d.swal = swal_nx;
            st_d.main = st_q.main - 1'b1;
            st_d.pre  = (swal_nx != '0) ? PRE_HI : PRE_LO;
        end else begin
            st_d.pre = st_q.pre - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.act  <= RST_WORD;
            st_q.main <= RST_WORD[WORD_W-1:PSW_SWAL_W];
            st_q.swal <= RST_WORD[PSW_SWAL_W-1:0];
            st_q.pre  <= (RST_WORD[PSW_SWAL_W-1:0] != '0) ? PRE_HI : PRE_LO;
        end else begin
            st_q <= st_d;
        end
    end

    // period measurement for the checks below
    logic [WORD_W-1:0] per_q;
    always_ff @(posedge clk) begin
        if (!rst_n)      per_q <= WORD_W'(1);
        else if (term_o) per_q <= WORD_W'(1);
        else             per_q <= per_q + 1'b1;
    end

    // R3
    period_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term_o |-> (per_q == st_q.act));
    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term_o |=> !term_o);
    // R5
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !term_o |=> (st_q.act == $past(st_q.act)));
    // R7
    swal_le_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.swal <= PSW_SWAL_W'(st_q.main) || st_q.main >= MAIN_W'(16));
    // R7
    mod_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pre == PRE_HI) |-> (st_q.swal != '0));
endmodule

// File: rtl/psw_divider.sv
module psw_divider
    import psw_pkg::*;
#(
    parameter int unsigned MAIN_W = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         word_wr_i,
    input  logic [MAIN_W+PSW_SWAL_W-1:0] word_i,
    output logic                         pulse_o
);
    localparam int unsigned WORD_W = MAIN_W + PSW_SWAL_W;

    logic [WORD_W-1:0] pend_w;
    logic              pend_vld;
    logic              term;

    psw_word_reg #(.WORD_W(WORD_W)) u_wreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (word_wr_i),
        .word_i     (word_i),
        .take_i     (term),
        .pend_o     (pend_w),
        .pend_vld_o (pend_vld)
    );

    psw_counter #(.MAIN_W(MAIN_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .nxt_word_i (pend_w),
        .nxt_vld_i  (pend_vld),
        .term_o     (term)
    );

    assign pulse_o = term;
endmodule

// File: tb/sim_psw_divider.sv
module sim_psw_lane #(
    parameter int unsigned MAIN_W = 12
) (
    input logic clk
);
    localparam int unsigned WORD_W = MAIN_W + 4;

    logic              rst_n;
    logic              wr_r;
    logic [WORD_W-1:0] word_r;
    logic              pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int k, act, pend, npulse;
    bit pv;

    psw_divider #(.MAIN_W(MAIN_W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_wr_i (wr_r),
        .word_i    (word_r),
        .pulse_o   (pulse)
    );

    task automatic step(input bit wr, input int w, input string tag);
        bit exp;
        exp = (k == act);
        n_chk++;
        if (pulse !== exp) begin
            n_fail++;
            $display("FAIL %s width %0d: pulse actual=%0b expected=%0b (cycle %0d of %0d)",
                     tag, MAIN_W, pulse, exp, k, act);
        end
        if (exp) begin
            k = 1;
            npulse++;
            if (pv) begin act = pend; pv = 0; end
        end else begin
            k++;
        end
        if (wr) begin
            pend = (w < 240) ? 240 : w;
            pv = 1;
        end
        wr_r   = wr;
        word_r = w[WORD_W-1:0];
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_word(input int w, input string tag);
        int p0;
        p0 = npulse;
        step(1, w, tag);
        while (npulse < p0 + 2) step(0, 0, tag);
    endtask

    task automatic run_pulses(input int n, input string tag);
        int p0;
        p0 = npulse;
        while (npulse < p0 + n) step(0, 0, tag);
    endtask

    initial begin
        int p0;
        rst_n = 0; wr_r = 0; word_r = '0;
        k = 1; act = 240; pend = 0; pv = 0; npulse = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (pulse !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 width %0d: pulse in reset actual=%0b expected=0", MAIN_W, pulse);
        end
        rst_n = 1;
        run_pulses(2, "R1");
        run_word(241, "R3");
        run_word(255, "R3");
        run_word(256, "R3");
        run_word(240, "R3");
        run_word(335, "R7");
        run_word(1000, "R2");
        run_word(100, "R4");
        run_word(0, "R4");
        // several writes before one boundary: last wins
        step(1, 300, "R6");
        step(1, 270, "R6");
        run_pulses(2, "R6");
        run_pulses(2, "R6");
        // write landing in the pulse cycle
        while (k != act) step(0, 0, "R5");
        step(1, 260, "R5");
        run_pulses(2, "R5");
        // write in the middle of a period
        p0 = npulse;
        repeat (50) step(0, 0, "R5");
        run_word(245, "R5");
        run_word((1 << WORD_W) - 1, "R8");
        done = 1;
    end
endmodule

module sim_psw_divider;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    sim_psw_lane #(.MAIN_W(12)) lane12 (.clk(clk));
    sim_psw_lane #(.MAIN_W(11)) lane11 (.clk(clk));

    initial begin
        int cyc;
        bit timed_out;
        int passed, total;
        cyc = 0;
        timed_out = 0;
        while (!(lane12.done && lane11.done) && !timed_out) begin
            @(posedge clk);
            cyc++;
            if (cyc >= 190000) timed_out = 1;
        end
        total  = lane12.n_chk + lane11.n_chk;
        passed = total - lane12.n_fail - lane11.n_fail;
        if (timed_out) begin
            total++;
            $display("FAIL R2 watchdog: actual=timeout expected=finish within %0d cycles", 190000);
        end
        $display("%0d/%0d checks passed", passed, total);
        $finish;
    end
endmodule